// File: doc/BRIEF.md
# Context-Tagged Store Queue with Per-Context Fence

This block is a single in-order queue that holds committed stores and cache-line flushes on their way to memory. Every entry is labelled with a small context number that names the logical task that issued it. Entries from all contexts share the one FIFO, so the order of operations inside any one context is simply queue order. The head entry is offered to the memory side and leaves the queue only when the memory side reports completion for it.

A fence is issued for one context. It waits only until every outstanding entry with that context number has retired. Entries of other contexts neither delay it nor are blocked by it. To find out when a context has drained without searching the queue, the block keeps one outstanding-entry counter per context number, indexed directly by that number. While a fence on a context is pending, new operations of that context are refused, and other contexts keep allocating. When more tasks run than there are context numbers, tasks share a number. The result stays correct, because sharing only adds ordering that was not strictly needed.

Top module: `ctx_store_queue`

## Requirements
- R1: The drain port always presents the oldest accepted entry, and entries leave in exactly the order they were accepted, whatever their contexts.
- R2: While `mem_valid` is high and `mem_done` is low, the head entry stays on the drain port unchanged and does not retire.
- R3: Op code (0 = store, 1 = flush), address, data and context number of an entry reach the drain port exactly as they were given at allocation.
- R4: A pending fence on context c is acknowledged only once no entry tagged c is outstanding. Outstanding entries of other contexts do not hold it back.
- R5: A fence request on a context with nothing outstanding is acknowledged in the cycle after the request is sampled.
- R6: `fence_ack[c]` is a one-cycle pulse per fence. After it the fence is no longer pending.
- R7: While a fence on context c is pending, `alloc_ready` is low for `alloc_ctx` = c and stays high for other contexts if the queue has room.
- R8: With DEPTH entries held, `alloc_ready` is low for every context. It rises again once an entry retires.
- R9: `ctx_drained[c]` is high exactly when no entry tagged c is outstanding. An allocation and a retirement of the same context in one cycle leave the count of that context unchanged.
- R10: Tasks that share a context number are fenced together: a fence on that number waits for the entries of all of those tasks.
- R11: After reset the queue is empty, `mem_valid` and `fence_ack` are low, every `ctx_drained` bit is high and `alloc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | 1 | 0 = store, 1 = flush |
| alloc_addr | input | ADDR_W | Address of the operation |
| alloc_data | input | DATA_W | Store data |
| alloc_ctx | input | CTX_W | Context number of the operation |
| alloc_ready | output | 1 | Entry accepted when high together with alloc_valid |
| fence_req | input | 2**CTX_W | One-cycle fence request, one bit per context |
| fence_ack | output | 2**CTX_W | One-cycle fence completion, one bit per context |
| ctx_drained | output | 2**CTX_W | High when the context has no outstanding entry |
| mem_valid | output | 1 | Head entry is present |
| mem_op | output | 1 | Op code of the head entry |
| mem_addr | output | ADDR_W | Address of the head entry |
| mem_data | output | DATA_W | Data of the head entry |
| mem_ctx | output | CTX_W | Context number of the head entry |
| mem_done | input | 1 | Memory side finished the head entry, which retires |

## Verification
The bench raises a fence on one context while another context holds older entries ahead of it in the queue. A design that drained the whole queue would hold the acknowledgement until the unrelated entry retired. It drives an allocation and a retirement of the same context in one cycle. A counter update that let one of the two win would show a drained context too early, or would never drain. It fills the queue to its depth, where an off-by-one in the occupancy would accept a ninth entry or stall one early. Two tasks aliased on one context number check that a fence cannot acknowledge after the first task's entry alone. A fence on an idle context must acknowledge on the next cycle and only for one cycle.

// File: rtl/ctq_pkg.sv
package ctq_pkg;
  typedef enum logic {
    OP_STORE = 1'b0,
    OP_FLUSH = 1'b1
  } ctq_op_e;

  function automatic int unsigned ctq_cnt_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/ctq_fifo.sv
module ctq_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 64,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [OCC_W-1:0] occ
);
  logic [WIDTH-1:0] store_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [OCC_W-1:0] occ_q, occ_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    occ_d = occ_q;
    case ({push, pop})
      2'b10:   occ_d = occ_q + OCC_W'(1);
      2'b01:   occ_d = occ_q - OCC_W'(1);
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wr_q] <= wdata;
  end

  assign rdata = store_q[rd_q];
  assign empty = (occ_q == '0);
  assign full  = (occ_q == OCC_W'(DEPTH));
  assign occ   = occ_q;
endmodule

// File: rtl/ctq_ctx_counters.sv
module ctq_ctx_counters #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CTX_W = 2,
  localparam int unsigned NCTX  = 1 << CTX_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inc_en,
  input  logic [CTX_W-1:0]            inc_ctx,
  input  logic                        dec_en,
  input  logic [CTX_W-1:0]            dec_ctx,
  output logic [NCTX-1:0][CNT_W-1:0]  cnt,
  output logic [NCTX-1:0]             zero
);
  for (genvar i = 0; i < NCTX; i++) begin : g_ctx
    logic             inc_hit, dec_hit;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign inc_hit = inc_en && (inc_ctx == CTX_W'(i));
    assign dec_hit = dec_en && (dec_ctx == CTX_W'(i));

    always_comb begin
      cnt_d = cnt_q;
      if (inc_hit && !dec_hit)      cnt_d = cnt_q + CNT_W'(1);
      else if (dec_hit && !inc_hit) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (inc_hit ^ dec_hit) cnt_q <= cnt_d;
    end

    assign cnt[i]  = cnt_q;
    assign zero[i] = (cnt_q == '0);
  end
endmodule

// File: rtl/ctq_fence_ctrl.sv
module ctq_fence_ctrl #(
  parameter int unsigned CTX_W = 2,
  localparam int unsigned NCTX = 1 << CTX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTX-1:0] req,
  input  logic [NCTX-1:0] drained,
  output logic [NCTX-1:0] pend,
  output logic [NCTX-1:0] ack
);
  logic [NCTX-1:0] pend_q, pend_d;

  always_comb begin
    ack    = pend_q & drained;
    pend_d = (pend_q & ~ack) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/ctx_store_queue.sv
module ctx_store_queue #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTX_W  = 2,
  localparam int unsigned NCTX  = 1 << CTX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_op,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic [CTX_W-1:0]  alloc_ctx,
  output logic              alloc_ready,
  input  logic [NCTX-1:0]   fence_req,
  output logic [NCTX-1:0]   fence_ack,
  output logic [NCTX-1:0]   ctx_drained,
  output logic              mem_valid,
  output logic              mem_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [CTX_W-1:0]  mem_ctx,
  input  logic              mem_done
);
  import ctq_pkg::*;

  localparam int unsigned ENT_W = 1 + CTX_W + ADDR_W + DATA_W;
  localparam int unsigned CNT_W = ctq_cnt_w(DEPTH);

  logic [ENT_W-1:0]            ent_in, ent_out;
  logic                        q_empty, q_full;
  logic [CNT_W-1:0]            occ;
  logic                        alloc_fire, retire;
  logic [NCTX-1:0]             fence_pend;
  logic [NCTX-1:0][CNT_W-1:0]  cnt_vec;
  ctq_op_e                     head_op;

  assign alloc_ready = !q_full && !fence_pend[alloc_ctx];
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign retire      = !q_empty && mem_done;
  assign ent_in      = {alloc_op, alloc_ctx, alloc_addr, alloc_data};

  ctq_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (alloc_fire),
    .wdata (ent_in),
    .pop   (retire),
    .rdata (ent_out),
    .empty (q_empty),
    .full  (q_full),
    .occ   (occ)
  );

  assign head_op   = ctq_op_e'(ent_out[ENT_W-1]);
  assign mem_valid = !q_empty;
  assign mem_op    = (head_op == OP_FLUSH);
  assign mem_ctx   = ent_out[ADDR_W+DATA_W +: CTX_W];
  assign mem_addr  = ent_out[DATA_W +: ADDR_W];
  assign mem_data  = ent_out[0 +: DATA_W];

  ctq_ctx_counters #(.DEPTH(DEPTH), .CTX_W(CTX_W)) cnt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (alloc_fire),
    .inc_ctx (alloc_ctx),
    .dec_en  (retire),
    .dec_ctx (mem_ctx),
    .cnt     (cnt_vec),
    .zero    (ctx_drained)
  );

  ctq_fence_ctrl #(.CTX_W(CTX_W)) fence_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (fence_req),
    .drained (ctx_drained),
    .pend    (fence_pend),
    .ack     (fence_ack)
  );
endmodule

// File: rtl/ctq_checker.sv
module ctq_checker #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTX_W  = 2,
  localparam int unsigned NCTX  = 1 << CTX_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       alloc_valid,
  input logic                       alloc_ready,
  input logic [CTX_W-1:0]           alloc_ctx,
  input logic [NCTX-1:0]            fence_req,
  input logic [NCTX-1:0]            fence_ack,
  input logic [NCTX-1:0]            ctx_drained,
  input logic                       mem_valid,
  input logic                       mem_op,
  input logic [ADDR_W-1:0]          mem_addr,
  input logic [DATA_W-1:0]          mem_data,
  input logic [CTX_W-1:0]           mem_ctx,
  input logic                       mem_done,
  input logic [CNT_W-1:0]           occ,
  input logic [NCTX-1:0]            fence_pend,
  input logic [NCTX-1:0][CNT_W-1:0] cnt_vec
);
  logic [CNT_W+CTX_W:0] cnt_sum;
  always_comb begin
    cnt_sum = '0;
    for (int k = 0; k < NCTX; k++) cnt_sum = cnt_sum + (CNT_W+CTX_W+1)'(cnt_vec[k]);
  end

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_done |=> mem_valid && $stable({mem_op, mem_ctx, mem_addr, mem_data})); // R2

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    occ == CNT_W'(DEPTH) |-> !alloc_ready); // R8

  AST_FENCED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready |-> !fence_pend[alloc_ctx]); // R7

  AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sum == (CNT_W+CTX_W+1)'(occ)); // R9

  for (genvar i = 0; i < NCTX; i++) begin : g_ctx_chk
    AST_ACK_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      fence_ack[i] |-> ctx_drained[i]); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fence_ack[i] && !fence_req[i] |=> !fence_ack[i]); // R6
    AST_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      fence_req[i] |=> fence_pend[i]); // R5
    AST_SAME_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid && alloc_ready && alloc_ctx == CTX_W'(i) &&
      mem_valid && mem_done && mem_ctx == CTX_W'(i) |=> $stable(cnt_vec[i])); // R9
  end
endmodule

bind ctx_store_queue ctq_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTX_W(CTX_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_ctx   (alloc_ctx),
  .fence_req   (fence_req),
  .fence_ack   (fence_ack),
  .ctx_drained (ctx_drained),
  .mem_valid   (mem_valid),
  .mem_op      (mem_op),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data),
  .mem_ctx     (mem_ctx),
  .mem_done    (mem_done),
  .occ         (occ),
  .fence_pend  (fence_pend),
  .cnt_vec     (cnt_vec)
);

// File: tb/ctx_store_queue_tb_top.sv
`timescale 1ns/100ps
module ctx_store_queue_tb_top;
  localparam int unsigned DEPTH  = 8;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTX_W  = 2;
  localparam int unsigned NCTX   = 1 << CTX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_valid;
  logic              alloc_op;
  logic [ADDR_W-1:0] alloc_addr;
  logic [DATA_W-1:0] alloc_data;
  logic [CTX_W-1:0]  alloc_ctx;
  logic              alloc_ready;
  logic [NCTX-1:0]   fence_req;
  logic [NCTX-1:0]   fence_ack;
  logic [NCTX-1:0]   ctx_drained;
  logic              mem_valid;
  logic              mem_op;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;
  logic [CTX_W-1:0]  mem_ctx;
  logic              mem_done;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ctx_store_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTX_W(CTX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_addr(alloc_addr),
    .alloc_data(alloc_data), .alloc_ctx(alloc_ctx), .alloc_ready(alloc_ready),
    .fence_req(fence_req), .fence_ack(fence_ack), .ctx_drained(ctx_drained),
    .mem_valid(mem_valid), .mem_op(mem_op), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ctx(mem_ctx), .mem_done(mem_done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_alloc(input logic op, input logic [31:0] a, input logic [31:0] d,
                          input logic [CTX_W-1:0] c);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_op = op; alloc_addr = a; alloc_data = d; alloc_ctx = c;
    #0.5;
    check("R7/R8 alloc accepted", 64'(alloc_ready), 64'd1);
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  task automatic do_pop(input string tag, input logic op, input logic [31:0] a,
                        input logic [31:0] d, input logic [CTX_W-1:0] c);
    @(negedge clk);
    check({tag, " valid"}, 64'(mem_valid), 64'd1);
    check({tag, " head"}, {29'd0, op, c, a}, {29'd0, mem_op, mem_ctx, mem_addr});
    check({tag, " data"}, 64'(mem_data), 64'(d));
    mem_done = 1'b1;
    @(posedge clk); #1;
    mem_done = 1'b0;
  endtask

  task automatic raise_fence(input int c);
    @(negedge clk);
    fence_req[c] = 1'b1;
    @(posedge clk); #1;
    fence_req = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 mem_valid", 64'(mem_valid), 64'd0);
    check("R11 fence_ack", 64'(fence_ack), 64'd0);
    check("R11 drained", 64'(ctx_drained), 64'hF);
    check("R11 alloc_ready", 64'(alloc_ready), 64'd1);
  endtask

  task automatic t_fence_idle();
    @(negedge clk);
    fence_req[2] = 1'b1;
    check("R5 no ack same cycle", 64'(fence_ack), 64'd0);
    @(posedge clk); #1;
    fence_req = '0;
    @(negedge clk);
    check("R5 ack next cycle", 64'(fence_ack), 64'h4);
    @(negedge clk);
    check("R6 ack single pulse", 64'(fence_ack), 64'd0);
  endtask

  task automatic t_order();
    do_alloc(1'b0, 32'h100, 32'hA0, 2'd0);
    do_alloc(1'b1, 32'h240, 32'hB1, 2'd1);
    do_alloc(1'b0, 32'h300, 32'hC2, 2'd0);
    repeat (2) @(negedge clk);
    check("R2 head held", 64'(mem_addr), 64'h100);
    check("R9 drained ctx0/ctx1 busy", 64'(ctx_drained), 64'hC);
    do_pop("R1 R3 first", 1'b0, 32'h100, 32'hA0, 2'd0);
    do_pop("R1 R3 second", 1'b1, 32'h240, 32'hB1, 2'd1);
    do_pop("R1 R3 third", 1'b0, 32'h300, 32'hC2, 2'd0);
    @(negedge clk);
    check("R9 all drained", 64'(ctx_drained), 64'hF);
  endtask

  task automatic t_scoped();
    do_alloc(1'b0, 32'h10, 32'h1, 2'd1);
    do_alloc(1'b1, 32'h20, 32'h2, 2'd2);
    raise_fence(2);
    @(negedge clk);
    alloc_ctx = 2'd2; #0.5;
    check("R7 fenced ctx refused", 64'(alloc_ready), 64'd0);
    alloc_ctx = 2'd1; #0.5;
    check("R7 other ctx accepted", 64'(alloc_ready), 64'd1);
    do_alloc(1'b0, 32'h30, 32'h3, 2'd1);
    @(negedge clk);
    check("R4 fence waits own ctx", 64'(fence_ack[2]), 64'd0);
    do_pop("R1 scoped A", 1'b0, 32'h10, 32'h1, 2'd1);
    @(negedge clk);
    check("R4 no ack while ctx2 outstanding", 64'(fence_ack[2]), 64'd0);
    do_pop("R1 scoped B", 1'b1, 32'h20, 32'h2, 2'd2);
    @(negedge clk);
    check("R4 ack despite ctx1 pending", 64'(fence_ack), 64'h4);
    check("R4 ctx1 still busy", 64'(ctx_drained[1]), 64'd0);
    @(negedge clk);
    alloc_ctx = 2'd2; #0.5;
    check("R6 fence cleared after ack", 64'(alloc_ready), 64'd1);
    do_pop("R1 scoped C", 1'b0, 32'h30, 32'h3, 2'd1);
  endtask

  task automatic t_alias();
    do_alloc(1'b1, 32'h400, 32'h11, 2'd3);
    do_alloc(1'b0, 32'h500, 32'h22, 2'd3);
    do_alloc(1'b0, 32'h600, 32'h33, 2'd0);
    raise_fence(3);
    do_pop("R10 task a", 1'b1, 32'h400, 32'h11, 2'd3);
    @(negedge clk);
    check("R10 shared id not yet drained", 64'(ctx_drained[3]), 64'd0);
    check("R10 no ack after first task", 64'(fence_ack[3]), 64'd0);
    do_pop("R10 task b", 1'b0, 32'h500, 32'h22, 2'd3);
    @(negedge clk);
    check("R10 ack after both tasks", 64'(fence_ack[3]), 64'd1);
    do_pop("R10 other ctx", 1'b0, 32'h600, 32'h33, 2'd0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) do_alloc(1'b0, 32'(32'h1000 + i), 32'(i), 2'd0);
    @(negedge clk);
    alloc_ctx = 2'd0; #0.5;
    check("R8 full refuses ctx0", 64'(alloc_ready), 64'd0);
    alloc_ctx = 2'd3; #0.5;
    check("R8 full refuses ctx3", 64'(alloc_ready), 64'd0);
    do_pop("R8 pop from full", 1'b0, 32'h1000, 32'd0, 2'd0);
    @(negedge clk); #0.5;
    check("R8 room again", 64'(alloc_ready), 64'd1);
    for (int i = 1; i < DEPTH; i++) do_pop("R1 full drain", 1'b0, 32'(32'h1000 + i), 32'(i), 2'd0);
    @(negedge clk);
    check("R9 drained after full", 64'(ctx_drained), 64'hF);
  endtask

  task automatic t_same_cycle();
    do_alloc(1'b0, 32'h70, 32'h7, 2'd1);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_op = 1'b1; alloc_addr = 32'h80; alloc_data = 32'h8; alloc_ctx = 2'd1;
    mem_done = 1'b1;
    @(posedge clk); #1;
    alloc_valid = 1'b0; mem_done = 1'b0;
    @(negedge clk);
    check("R9 same-cycle count held", 64'(ctx_drained[1]), 64'd0);
    check("R1 new head after swap", 64'(mem_addr), 64'h80);
    do_pop("R9 last ctx1", 1'b1, 32'h80, 32'h8, 2'd1);
    @(negedge clk);
    check("R9 ctx1 drained", 64'(ctx_drained[1]), 64'd1);
    check("R2 queue empty", 64'(mem_valid), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_op = 1'b0; alloc_addr = '0;
    alloc_data = '0; alloc_ctx = '0; fence_req = '0; mem_done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fence_idle();
    t_order();
    t_scoped();
    t_alias();
    t_full();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule